// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Unit

This block builds the interrupt status for a serial peripheral core with a transmit FIFO and a receive FIFO. It watches the live fill levels of both FIFOs and three one-cycle error strobes, and turns them into a seven-bit status word. Four of the bits are level comparisons against two programmable thresholds. Three are sticky error flags that software clears by writing ones back to the status offset.

A seven-bit mask decides which status bits may raise the single interrupt line. Software never writes the mask directly. It writes ones to one offset to set mask bits and ones to another offset to clear them, and it reads the current mask at a third offset. The FIFO storage and the shift engine are outside the block. Its interface is a simple register write/read port plus the level and event inputs.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset the mask reads 0, both thresholds read 1, all sticky bits are 0, irq is 0, and with both fill levels at 0 the status reads 0x04.
- R2: Status bit 4 (receive at-or-above threshold) is 1 exactly when rx_level >= the receive threshold.
- R3: Status bit 2 (transmit below threshold) is 1 exactly when tx_level < the transmit threshold.
- R4: Status bit 3 is 1 exactly when tx_level equals DEPTH, and status bit 5 is 1 exactly when rx_level equals DEPTH.
- R5: A one-cycle pulse on rx_overflow_evt, mode_fault_evt or tx_underflow_evt sets status bit 0, 1 or 6 respectively, and the bit then stays 1 until it is cleared.
- R6: A write to offset 0x04 clears each sticky bit (0, 1, 6) whose write-data bit is 1, and leaves those whose write-data bit is 0.
- R7: If a sticky bit's event pulse and a clearing write to 0x04 fall in the same cycle, the bit is 1 afterwards.
- R8: Bits 2 to 5 ignore writes to 0x04 and keep following the live comparisons.
- R9: A write to 0x08 sets the mask bits given by write-data bits [6:0]; a write to 0x0C clears them; other mask bits keep their value; the mask reads at 0x10, and 0x08 and 0x0C read as 0.
- R10: irq is a register that equals the OR of (status AND mask) from the previous cycle, so a change reaches irq one clock edge later.
- R11: Offsets 0x28 and 0x2C hold the transmit and receive thresholds, storing write-data bits [LVL_W-1:0] (bits [4:0] at the default DEPTH of 16), and they read back zero-extended.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Register byte offset for reads and writes |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| tx_level | input | LVL_W (5) | Transmit FIFO fill level, 0 to DEPTH |
| rx_level | input | LVL_W (5) | Receive FIFO fill level, 0 to DEPTH |
| rx_overflow_evt | input | 1 | One-cycle receive overflow strobe |
| tx_underflow_evt | input | 1 | One-cycle transmit underflow strobe |
| mode_fault_evt | input | 1 | One-cycle mode fault strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
The two functions that can fall in the same cycle are the setting of a sticky error flag by its event strobe and its clearing by a write of ones to the status offset. The bench first leaves the overflow and underflow flags set. It then raises the overflow strobe in the very cycle that writes ones to bits 0 and 6. The status is read back afterwards: bit 0 must still be set because the event wins, and bit 6 must be clear because it had no event. Separately, a clearing write made while both FIFOs sit at full level must leave the level bits untouched.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

    localparam int STAT_W = 7;

    // status bit positions (decoded by software)
    localparam int B_RX_OVF  = 0;
    localparam int B_MODE_F  = 1;
    localparam int B_TX_LOW  = 2;
    localparam int B_TX_FULL = 3;
    localparam int B_RX_HIGH = 4;
    localparam int B_RX_FULL = 5;
    localparam int B_TX_UNF  = 6;

    // register byte offsets
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [7:0] OFS_MSET   = 8'h08;
    localparam logic [7:0] OFS_MCLR   = 8'h0C;
    localparam logic [7:0] OFS_MASK   = 8'h10;
    localparam logic [7:0] OFS_TX_THR = 8'h28;
    localparam logic [7:0] OFS_RX_THR = 8'h2C;

    typedef logic [STAT_W-1:0] stat_t;

endpackage

// File: rtl/sfi_level_cmp.sv
module sfi_level_cmp #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    output logic             tx_low,
    output logic             tx_full,
    output logic             rx_high,
    output logic             rx_full
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    always_comb begin
        tx_low  = (tx_level < tx_thr);
        rx_high = (rx_level >= rx_thr);
        tx_full = (tx_level == FULL_LVL);
        rx_full = (rx_level == FULL_LVL);
    end

endmodule

// File: rtl/sfi_sticky.sv
module sfi_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);

    typedef struct packed {
        logic [N-1:0] flag;
    } st_t;

    st_t st_d, st_q;

    // an event in the clearing cycle keeps its flag set
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            st_d.flag[i] = evt[i] | (st_q.flag[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/sfi_regbank.sv
module sfi_regbank
    import spi_fifo_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  stat_t             status,
    output stat_t             mask,
    output logic [LVL_W-1:0]  tx_thr,
    output logic [LVL_W-1:0]  rx_thr,
    output stat_t             w1c,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        stat_t            mask;
        logic [LVL_W-1:0] tx_thr;
        logic [LVL_W-1:0] rx_thr;
    } regs_t;

    regs_t r_d, r_q;

    logic  hit_status, hit_mset, hit_mclr, hit_txthr, hit_rxthr;
    stat_t wbits;
    logic  unused_wdata;

    assign wbits        = wdata[STAT_W-1:0];
    assign unused_wdata = ^wdata[DATA_W-1:STAT_W];

    always_comb begin
        hit_status = wr_en && (addr == ADDR_W'(OFS_STATUS));
        hit_mset   = wr_en && (addr == ADDR_W'(OFS_MSET));
        hit_mclr   = wr_en && (addr == ADDR_W'(OFS_MCLR));
        hit_txthr  = wr_en && (addr == ADDR_W'(OFS_TX_THR));
        hit_rxthr  = wr_en && (addr == ADDR_W'(OFS_RX_THR));
    end

    always_comb begin
        r_d = r_q;
        if (hit_mset)  r_d.mask   = r_q.mask | wbits;
        if (hit_mclr)  r_d.mask   = r_q.mask & ~wbits;
        if (hit_txthr) r_d.tx_thr = wdata[LVL_W-1:0];
        if (hit_rxthr) r_d.rx_thr = wdata[LVL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mask   <= '0;
            r_q.tx_thr <= LVL_W'(1);
            r_q.rx_thr <= LVL_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign w1c = hit_status ? wbits : '0;

    always_comb begin
        rdata = '0;
        if      (addr == ADDR_W'(OFS_STATUS)) rdata = DATA_W'(status);
        else if (addr == ADDR_W'(OFS_MASK))   rdata = DATA_W'(r_q.mask);
        else if (addr == ADDR_W'(OFS_TX_THR)) rdata = DATA_W'(r_q.tx_thr);
        else if (addr == ADDR_W'(OFS_RX_THR)) rdata = DATA_W'(r_q.rx_thr);
    end

    assign mask   = r_q.mask;
    assign tx_thr = r_q.tx_thr;
    assign rx_thr = r_q.rx_thr;

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_overflow_evt,
    input  logic              tx_underflow_evt,
    input  logic              mode_fault_evt,
    output logic              irq
);

    localparam int N_STICKY = 3;

    stat_t            status_w;
    stat_t            mask_q;
    stat_t            w1c;
    logic [LVL_W-1:0] tx_thr_q, rx_thr_q;
    logic             tx_low, tx_full, rx_high, rx_full;
    logic [N_STICKY-1:0] err_evt, err_clr, err_flag;

    sfi_regbank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .status (status_w),
        .mask   (mask_q),
        .tx_thr (tx_thr_q),
        .rx_thr (rx_thr_q),
        .w1c    (w1c),
        .rdata  (bus_rdata)
    );

    sfi_level_cmp #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_cmp (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr_q),
        .rx_thr   (rx_thr_q),
        .tx_low   (tx_low),
        .tx_full  (tx_full),
        .rx_high  (rx_high),
        .rx_full  (rx_full)
    );

    // sticky slot order: 0 rx overflow, 1 mode fault, 2 tx underflow
    assign err_evt = {tx_underflow_evt, mode_fault_evt, rx_overflow_evt};
    assign err_clr = {w1c[B_TX_UNF], w1c[B_MODE_F], w1c[B_RX_OVF]};

    sfi_sticky #(
        .N (N_STICKY)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (err_evt),
        .clr   (err_clr),
        .flag  (err_flag)
    );

    always_comb begin
        status_w            = '0;
        status_w[B_RX_OVF]  = err_flag[0];
        status_w[B_MODE_F]  = err_flag[1];
        status_w[B_TX_LOW]  = tx_low;
        status_w[B_TX_FULL] = tx_full;
        status_w[B_RX_HIGH] = rx_high;
        status_w[B_RX_FULL] = rx_full;
        status_w[B_TX_UNF]  = err_flag[2];
    end

    typedef struct packed {
        logic irq;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.irq = |(status_w & mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq = o_q.irq;

endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk
    import spi_fifo_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [LVL_W-1:0]  rx_level,
    input logic [LVL_W-1:0]  rx_thr_q,
    input logic              rx_overflow_evt,
    input stat_t             status_w,
    input stat_t             mask_q,
    input logic              irq
);

    logic wr_status, wr_mset, wr_mclr;
    assign wr_status = bus_wr_en && (bus_addr == ADDR_W'(OFS_STATUS));
    assign wr_mset   = bus_wr_en && (bus_addr == ADDR_W'(OFS_MSET));
    assign wr_mclr   = bus_wr_en && (bus_addr == ADDR_W'(OFS_MCLR));

    p_rx_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[B_RX_HIGH] == (rx_level >= rx_thr_q));

    p_ovf_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow_evt |=> status_w[B_RX_OVF]);

    p_ovf_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && bus_wdata[B_RX_OVF] && !rx_overflow_evt) |=> !status_w[B_RX_OVF]);

    p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w[B_RX_OVF] && !wr_status) |=> status_w[B_RX_OVF]);

    p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && bus_wdata[B_RX_OVF] && rx_overflow_evt) |=> status_w[B_RX_OVF]);

    p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(bus_wdata[STAT_W-1:0])) == $past(bus_wdata[STAT_W-1:0])));

    p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(bus_wdata[STAT_W-1:0])) == '0));

    p_irq_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(status_w & mask_q)));

endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LVL_W  (LVL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr_en       (bus_wr_en),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .rx_level        (rx_level),
    .rx_thr_q        (rx_thr_q),
    .rx_overflow_evt (rx_overflow_evt),
    .status_w        (status_w),
    .mask_q          (mask_q),
    .irq             (irq)
);

// File: tb/spi_fifo_irq_tb.sv
module spi_fifo_irq_tb;

    localparam int DEPTH  = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int LVL_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [LVL_W-1:0]  tx_level = '0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic              rx_overflow_evt = 1'b0;
    logic              tx_underflow_evt = 1'b0;
    logic              mode_fault_evt = 1'b0;
    logic              irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    spi_fifo_irq #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_wr_en        (bus_wr_en),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .tx_level         (tx_level),
        .rx_level         (rx_level),
        .rx_overflow_evt  (rx_overflow_evt),
        .tx_underflow_evt (tx_underflow_evt),
        .mode_fault_evt   (mode_fault_evt),
        .irq              (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_levels(input int tx, input int rx);
        @(negedge clk);
        tx_level = LVL_W'(tx); rx_level = LVL_W'(rx);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd(8'h04, v); check("R1 status", v, 32'h04);
        rd(8'h10, v); check("R1 mask", v, 32'h0);
        rd(8'h28, v); check("R1 tx thr", v, 32'd1);
        rd(8'h2C, v); check("R1 rx thr", v, 32'd1);
    endtask

    task automatic t_rx_thr;
        logic [31:0] v;
        set_levels(0, 1);
        rd(8'h04, v); check("R2 rx 1 thr 1", {31'd0, v[4]}, 32'd1);
        wr(8'h2C, 32'hFFFF_FFE5);
        rd(8'h2C, v); check("R11 rx thr readback", v, 32'd5);
        set_levels(0, 4);
        rd(8'h04, v); check("R2 rx 4 thr 5", {31'd0, v[4]}, 32'd0);
        set_levels(0, 5);
        rd(8'h04, v); check("R2 rx 5 thr 5", {31'd0, v[4]}, 32'd1);
        set_levels(0, 6);
        rd(8'h04, v); check("R2 rx 6 thr 5", {31'd0, v[4]}, 32'd1);
        wr(8'h2C, 32'd1);
        set_levels(0, 0);
    endtask

    task automatic t_tx_thr;
        logic [31:0] v;
        set_levels(1, 0);
        rd(8'h04, v); check("R3 tx 1 thr 1", {31'd0, v[2]}, 32'd0);
        wr(8'h28, 32'd8);
        rd(8'h28, v); check("R11 tx thr readback", v, 32'd8);
        set_levels(7, 0);
        rd(8'h04, v); check("R3 tx 7 thr 8", {31'd0, v[2]}, 32'd1);
        set_levels(8, 0);
        rd(8'h04, v); check("R3 tx 8 thr 8", {31'd0, v[2]}, 32'd0);
        wr(8'h28, 32'd1);
        set_levels(0, 0);
    endtask

    task automatic t_full;
        logic [31:0] v;
        set_levels(16, 15);
        rd(8'h04, v); check("R4 tx full rx 15", {30'd0, v[5], v[3]}, 32'b01);
        set_levels(15, 16);
        rd(8'h04, v); check("R4 tx 15 rx full", {30'd0, v[5], v[3]}, 32'b10);
        set_levels(0, 0);
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        @(negedge clk); mode_fault_evt = 1'b1;
        @(negedge clk); mode_fault_evt = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h04, v); check("R5 mode fault held", v, 32'h06);
        @(negedge clk); rx_overflow_evt = 1'b1; tx_underflow_evt = 1'b1;
        @(negedge clk); rx_overflow_evt = 1'b0; tx_underflow_evt = 1'b0;
        rd(8'h04, v); check("R5 all sticky", v, 32'h47);
        wr(8'h04, 32'h02);
        rd(8'h04, v); check("R6 clear bit1 only", v, 32'h45);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h41; rx_overflow_evt = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0; rx_overflow_evt = 1'b0;
        rd(8'h04, v); check("R7 event beats clear", v, 32'h05);
        wr(8'h04, 32'h01);
        rd(8'h04, v); check("R6 clear bit0", v, 32'h04);
    endtask

    task automatic t_level_w1c;
        logic [31:0] v;
        set_levels(16, 16);
        wr(8'h04, 32'h7F);
        rd(8'h04, v); check("R8 level bits after w1c", v, 32'h38);
        set_levels(0, 0);
        rd(8'h04, v); check("R8 level bits follow", v, 32'h04);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(8'h08, 32'h11);
        rd(8'h10, v); check("R9 set 0x11", v, 32'h11);
        wr(8'h08, 32'h04);
        rd(8'h10, v); check("R9 set 0x04", v, 32'h15);
        wr(8'h0C, 32'h05);
        rd(8'h10, v); check("R9 clear 0x05", v, 32'h10);
        rd(8'h08, v); check("R9 set reg reads 0", v, 32'h0);
        rd(8'h0C, v); check("R9 clear reg reads 0", v, 32'h0);
    endtask

    task automatic t_irq;
        // mask holds only bit 4 here; rx thr 1
        @(negedge clk);
        check("R10 idle irq", {31'd0, irq}, 32'd0);
        rx_level = LVL_W'(1);
        #1 check("R10 not combinational", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R10 irq one edge later", {31'd0, irq}, 32'd1);
        rx_level = '0;
        @(negedge clk);
        check("R10 irq drops", {31'd0, irq}, 32'd0);
        @(negedge clk); tx_underflow_evt = 1'b1;
        @(negedge clk); tx_underflow_evt = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 unmasked sticky no irq", {31'd0, irq}, 32'd0);
        wr(8'h08, 32'h40);
        @(negedge clk);
        check("R10 masked sticky irq", {31'd0, irq}, 32'd1);
        wr(8'h04, 32'h40);
        @(negedge clk);
        check("R10 cleared sticky irq", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_thr();
        t_tx_thr();
        t_full();
        t_sticky();
        t_collision();
        t_level_w1c();
        t_mask();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule